// File: doc/BRIEF.md
# Timer capture input conditioner

This block sits in front of one capture channel of a timer. It conditions a raw pin signal: the signal first passes a two-stage synchronizer, then a digital noise filter that only moves its output after a programmable number of consecutive samples at the new level. A 4-bit filter code chooses both how often the filter samples and how many agreeing samples it needs. Sampling can run on every system clock, on a clock-input rate enable, or on a dead-time rate enable divided by 2 to 32 through a free-running prescaler.

A 2-bit source select then picks what the channel passes on to capture. It can mark the channel as an output, take the channel's own filtered pin, take the neighbouring channel's conditioned pin, or take the trigger-controller signal. The select register can only be written while the channel is disabled. All rate enables are single-cycle pulses in the system clock domain, so there is only one clock.

Top module: `capin_front`

## Requirements
- R1: The source select encodes 00 = output mode (`sel_out` 0, `is_output` 1), 01 = own filtered pin, 10 = `nbr_in`, 11 = `trig_in`. `sel_out` and `is_output` are registered and reflect the select and the source values of the previous cycle.
- R2: A write on `sel_wr` updates the select, readable on `sel_mode`, only when `chan_en` is 0. A write while `chan_en` is 1 leaves `sel_mode` unchanged.
- R3: With a nonzero code, the filter counts consecutive sampling enables at which the synchronized input differs from `filt_out`. `filt_out` takes the new level at the N-th such sample. Any sample equal to `filt_out` returns the count to zero, so shorter pulses never reach the output.
- R4: Code 0000 disables filtering: `filt_out` follows the synchronized input on every system clock, three cycles after `pin_raw` changes.
- R5: Codes 0001, 0010 and 0011 sample on `clkin_tick`, with N = 2, 4 and 8.
- R6: Codes 0100 to 1001 sample on the dead-time rate divided by 2, 2, 4, 4, 8, 8, with N = 6, 8, 6, 8, 6, 8. The prescaler counts `dts_tick` pulses modulo 32 from reset. A sample is taken on a `dts_tick` that arrives while the count modulo the divisor equals divisor−1.
- R7: Codes 1010 to 1111 sample on the dead-time rate divided by 16, 16, 16, 32, 32, 32, with N = 5, 6, 8, 5, 6, 8, on the same prescaler as R6.
- R8: After reset `filt_out` is 0, the count is 0, `sel_mode` is 00, `is_output` is 1, `sel_out` is 0 and the filter code is 0000.
- R9: A `code_wr` with a value different from the current code clears the count, takes no sample in that cycle and leaves `filt_out` unchanged. A new N-sample run is then needed.
- R10: `pin_raw` passes two synchronizer flops before the filter. With code 0000, `filt_out` has not changed two cycles after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous raw pin of this channel |
| nbr_in | input | 1 | Neighbouring channel's conditioned pin signal |
| trig_in | input | 1 | Trigger-controller signal |
| clkin_tick | input | 1 | Single-cycle enable at the clock-input rate |
| dts_tick | input | 1 | Single-cycle enable at the dead-time base rate |
| chan_en | input | 1 | Channel enable; locks the source select while 1 |
| sel_wr | input | 1 | Source-select write strobe |
| sel_wdata | input | 2 | Source-select write value |
| code_wr | input | 1 | Filter-code write strobe |
| code_wdata | input | 4 | Filter-code write value |
| filt_out | output | 1 | Filtered level of `pin_raw` |
| sel_out | output | 1 | Selected channel input (0 in output mode) |
| is_output | output | 1 | 1 when the channel is in output mode |
| sel_mode | output | 2 | Current source select |

## Verification
The bench targets the exact sample on which the filter moves. Runs of N−1 differing samples must leave the output alone, and the N-th must move it. A counter off by one would let a glitch through or delay every edge by one sample period. A filter code change in the middle of a run is checked. A design that kept the partial count would switch too early, or would overrun the new, smaller N and miss the switch. Divided dead-time modes are checked against a free-running prescaler phase, which catches a prescaler that restarts or counts system clocks. Select writes while the channel is enabled are checked on `sel_mode`, which catches a lock that leaks.

// File: rtl/capin_pkg.sv
package capin_pkg;

  typedef enum logic [1:0] {
    SRC_OUT = 2'b00,
    SRC_OWN = 2'b01,
    SRC_NBR = 2'b10,
    SRC_TRG = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    RATE_SYS   = 2'd0,
    RATE_CLKIN = 2'd1,
    RATE_DTS   = 2'd2
  } rate_e;

  typedef struct packed {
    rate_e      rate;
    logic [2:0] div_log2;
    logic [3:0] n_req;
  } flt_cfg_t;

  // Split a filter code into sampling source, divisor exponent and sample count.
  function automatic flt_cfg_t decode_code(input logic [3:0] code);
    flt_cfg_t   r;
    logic [3:0] k;
    r.rate     = RATE_SYS;
    r.div_log2 = 3'd0;
    r.n_req    = 4'd1;
    k          = 4'd0;
    if (code == 4'd0) begin
      r.rate = RATE_SYS;
    end else if (code <= 4'd3) begin
      r.rate  = RATE_CLKIN;
      r.n_req = 4'd1 << code[1:0];
    end else if (code <= 4'd9) begin
      k          = code - 4'd4;
      r.rate     = RATE_DTS;
      r.div_log2 = 3'(k[3:1]) + 3'd1;
      r.n_req    = k[0] ? 4'd8 : 4'd6;
    end else begin
      k          = code - 4'd10;
      r.rate     = RATE_DTS;
      r.div_log2 = (k >= 4'd3) ? 3'd5 : 3'd4;
      case ((k >= 4'd3) ? (k - 4'd3) : k)
        4'd0:    r.n_req = 4'd5;
        4'd1:    r.n_req = 4'd6;
        default: r.n_req = 4'd8;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/capin_rate_gen.sv
module capin_rate_gen
  import capin_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clkin_tick,
  input  logic       dts_tick,
  input  rate_e      rate,
  input  logic [2:0] div_log2,
  output logic       samp_en
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             dts_hit;

  // Free-running prescaler on dead-time ticks; never restarted by code changes.
  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (dts_tick) pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    mask    = PRE_W'((32'd1 << div_log2) - 32'd1);
    dts_hit = dts_tick && ((pre_q & mask) == mask);
    case (rate)
      RATE_SYS:   samp_en = 1'b1;
      RATE_CLKIN: samp_en = clkin_tick;
      RATE_DTS:   samp_en = dts_hit;
      default:    samp_en = 1'b0;
    endcase
  end

  // R5: clock-input modes sample only on the clock-input enable
  assert_clkin_only_R5: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_CLKIN && samp_en) |-> clkin_tick);

  // R6: divided modes sample only on a dead-time tick
  assert_dts_only_R6: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_DTS && samp_en) |-> dts_tick);

endmodule

// File: rtl/capin_filter.sv
module capin_filter #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_raw,
  input  logic       samp_en,
  input  logic       bypass,
  input  logic [3:0] n_req,
  input  logic       clr,
  output logic       filt_q
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       last_cnt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
  end

  assign smp      = sync_q[SYNC_STAGES-1];
  assign last_cnt = CNT_W'(n_req - 4'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr) begin
      cnt_q  <= '0;
    end else if (bypass) begin
      filt_q <= smp;
      cnt_q  <= '0;
    end else if (samp_en) begin
      if (smp == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == last_cnt) begin
        filt_q <= smp;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3: the run count never reaches the required count
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    !bypass |-> (cnt_q < CNT_W'(n_req)));

  // R3: the output only moves on a sampling cycle without a clear
  assert_move_on_sample_R3: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> (($past(samp_en) || $past(bypass)) && !$past(clr)));

  // R9: a code change empties the count and keeps the level
  assert_clear_keeps_level_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0) && (filt_q == $past(filt_q)));

endmodule

// File: rtl/capin_src_sel.sv
module capin_src_sel
  import capin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       chan_en,
  input  logic       sel_wr,
  input  logic [1:0] sel_wdata,
  input  logic       own_in,
  input  logic       nbr_in,
  input  logic       trig_in,
  output src_e       mode_q,
  output logic       sel_out,
  output logic       is_output
);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= SRC_OUT;
    else if (sel_wr && !chan_en) mode_q <= src_e'(sel_wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_out   <= 1'b0;
      is_output <= 1'b1;
    end else begin
      is_output <= (mode_q == SRC_OUT);
      case (mode_q)
        SRC_OWN: sel_out <= own_in;
        SRC_NBR: sel_out <= nbr_in;
        SRC_TRG: sel_out <= trig_in;
        default: sel_out <= 1'b0;
      endcase
    end
  end

  // R2: an enabled channel keeps its select
  assert_sel_locked_R2: assert property (@(posedge clk) disable iff (rst)
    (chan_en && sel_wr) |=> (mode_q == $past(mode_q)));

  // R1: output mode drives a quiet input
  assert_out_mode_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == SRC_OUT) |-> (is_output && !sel_out));

  // R1: trigger mode forwards the trigger one cycle later
  assert_trig_path_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == SRC_TRG) |-> (sel_out == $past(trig_in)));

endmodule

// File: rtl/capin_front.sv
module capin_front
  import capin_pkg::*;
#(
  parameter int PRE_W       = 5,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_raw,
  input  logic       nbr_in,
  input  logic       trig_in,
  input  logic       clkin_tick,
  input  logic       dts_tick,
  input  logic       chan_en,
  input  logic       sel_wr,
  input  logic [1:0] sel_wdata,
  input  logic       code_wr,
  input  logic [3:0] code_wdata,
  output logic       filt_out,
  output logic       sel_out,
  output logic       is_output,
  output logic [1:0] sel_mode
);

  logic [3:0] code_q;
  flt_cfg_t   cfg;
  logic       clr;
  logic       samp_en;
  logic       filt_w;
  src_e       mode_w;

  always_ff @(posedge clk) begin
    if (rst) code_q <= 4'd0;
    else if (code_wr) code_q <= code_wdata;
  end

  assign clr = code_wr && (code_wdata != code_q);
  assign cfg = decode_code(code_q);

  capin_rate_gen #(.PRE_W(PRE_W)) u_rate (
    .clk        (clk),
    .rst        (rst),
    .clkin_tick (clkin_tick),
    .dts_tick   (dts_tick),
    .rate       (cfg.rate),
    .div_log2   (cfg.div_log2),
    .samp_en    (samp_en)
  );

  capin_filter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .pin_raw (pin_raw),
    .samp_en (samp_en),
    .bypass  (cfg.rate == RATE_SYS),
    .n_req   (cfg.n_req),
    .clr     (clr),
    .filt_q  (filt_w)
  );

  capin_src_sel u_sel (
    .clk       (clk),
    .rst       (rst),
    .chan_en   (chan_en),
    .sel_wr    (sel_wr),
    .sel_wdata (sel_wdata),
    .own_in    (filt_w),
    .nbr_in    (nbr_in),
    .trig_in   (trig_in),
    .mode_q    (mode_w),
    .sel_out   (sel_out),
    .is_output (is_output)
  );

  assign filt_out = filt_w;
  assign sel_mode = mode_w;

  // R1: own-pin mode forwards the filtered level one cycle later
  assert_own_path_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_mode) == 2'b01) |-> (sel_out == $past(filt_out)));

endmodule

// File: tb/capin_front_bench.sv
module capin_front_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_raw = 1'b0, nbr_in = 1'b0, trig_in = 1'b0;
  logic       clkin_tick = 1'b0, dts_tick = 1'b0, chan_en = 1'b0;
  logic       sel_wr = 1'b0, code_wr = 1'b0;
  logic [1:0] sel_wdata = 2'd0;
  logic [3:0] code_wdata = 4'd0;
  logic       filt_out, sel_out, is_output;
  logic [1:0] sel_mode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  capin_front u_capin_front (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .nbr_in(nbr_in), .trig_in(trig_in),
    .clkin_tick(clkin_tick), .dts_tick(dts_tick), .chan_en(chan_en),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .code_wr(code_wr), .code_wdata(code_wdata),
    .filt_out(filt_out), .sel_out(sel_out), .is_output(is_output), .sel_mode(sel_mode)
  );

  // Expected sample count per code, from R5..R7
  function automatic int exp_n(input int c);
    case (c)
      1: return 2;  2: return 4;  3: return 8;
      4: return 6;  5: return 8;  6: return 6;  7: return 8;
      8: return 6;  9: return 8;  10: return 5; 11: return 6;
      12: return 8; 13: return 5; 14: return 6; 15: return 8;
      default: return 1;
    endcase
  endfunction

  // Expected dead-time divisor per code, from R6 and R7
  function automatic int exp_div(input int c);
    case (c)
      4, 5: return 2;
      6, 7: return 4;
      8, 9: return 8;
      10, 11, 12: return 16;
      13, 14, 15: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic string code_tag(input int c);
    if (c == 0) return "R4";
    if (c <= 3) return "R5";
    if (c <= 9) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference model of the requirements
  int m_s1, m_s2, m_filt, m_cnt, m_code, m_pre, m_mode, m_sel, m_isout;
  always @(posedge clk) begin
    int samp;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_filt <= 0; m_cnt <= 0; m_code <= 0; m_pre <= 0;
      m_mode <= 0; m_sel <= 0; m_isout <= 1;
    end else begin
      m_s1 <= int'(pin_raw);
      m_s2 <= m_s1;
      if (dts_tick) m_pre <= (m_pre + 1) % 32;
      if (m_code == 0) samp = 1;
      else if (m_code <= 3) samp = int'(clkin_tick);
      else samp = (dts_tick && (m_pre % exp_div(m_code)) == exp_div(m_code) - 1) ? 1 : 0;
      if (code_wr && int'(code_wdata) != m_code) begin
        m_cnt <= 0;
      end else if (m_code == 0) begin
        m_filt <= m_s2; m_cnt <= 0;
      end else if (samp != 0) begin
        if (m_s2 == m_filt) m_cnt <= 0;
        else if (m_cnt + 1 == exp_n(m_code)) begin m_filt <= m_s2; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
      if (code_wr) m_code <= int'(code_wdata);
      if (sel_wr && !chan_en) m_mode <= int'(sel_wdata);
      m_isout <= (m_mode == 0) ? 1 : 0;
      case (m_mode)
        1: m_sel <= m_filt;
        2: m_sel <= int'(nbr_in);
        3: m_sel <= int'(trig_in);
        default: m_sel <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(code_tag(m_code), "filt_out vs model", int'(filt_out), m_filt);
      chk("R1", "sel_out vs model", int'(sel_out), m_sel);
      chk("R1", "is_output vs model", int'(is_output), m_isout);
      chk("R2", "sel_mode vs model", int'(sel_mode), m_mode);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_code(input int v);
    code_wr = 1'b1; code_wdata = 4'(v);
    @(negedge clk);
    code_wr = 1'b0;
  endtask

  task automatic wr_sel(input int v);
    sel_wr = 1'b1; sel_wdata = 2'(v);
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  initial begin
    #(64'd200000 * 64'd20);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = int'($urandom(32'd20240611));
    step(5);
    rst = 1'b0;
    step(1);
    // R8: reset state
    chk("R8", "filt_out after reset", int'(filt_out), 0);
    chk("R8", "sel_out after reset", int'(sel_out), 0);
    chk("R8", "is_output after reset", int'(is_output), 1);
    chk("R8", "sel_mode after reset", int'(sel_mode), 0);

    // R2: select lock
    wr_sel(1);
    chk("R2", "select written while disabled", int'(sel_mode), 1);
    chan_en = 1'b1;
    wr_sel(3);
    step(1);
    chk("R2", "select write while enabled ignored", int'(sel_mode), 1);
    chan_en = 1'b0;
    wr_sel(2);
    chk("R2", "select written after disable", int'(sel_mode), 2);
    wr_sel(1);

    // R10 / R4: bypass latency
    wr_code(0);
    step(5);
    pin_raw = 1'b1;
    step(2);
    chk("R10", "filt_out still low two cycles after pin", int'(filt_out), 0);
    step(1);
    chk("R4", "filt_out high three cycles after pin", int'(filt_out), 1);
    step(1);
    chk("R1", "own mode forwards filtered level", int'(sel_out), 1);

    // R3: glitch rejection with N=2 on clock-input rate
    wr_code(1);
    clkin_tick = 1'b1;
    pin_raw = 1'b0;
    step(10);
    chk("R3", "filter returns low", int'(filt_out), 0);
    pin_raw = 1'b1;
    step(1);
    pin_raw = 1'b0;
    step(8);
    chk("R3", "one-sample glitch rejected", int'(filt_out), 0);
    pin_raw = 1'b1;
    step(3);
    chk("R3", "no change after N-1 samples", int'(filt_out), 0);
    step(1);
    chk("R3", "change at N-th sample", int'(filt_out), 1);

    // R9: code change mid-run restarts the count
    wr_code(3);
    step(20);
    pin_raw = 1'b0;
    step(8);
    wr_code(2);
    chk("R9", "level kept across code change", int'(filt_out), 1);
    step(3);
    chk("R9", "count restarted after code change", int'(filt_out), 1);
    step(1);
    chk("R9", "switch after full new run", int'(filt_out), 0);

    // Random phase over every code
    for (int c = 0; c < 16; c++) begin
      int hold;
      int span;
      wr_code(c);
      if (c == 0) span = 6;
      else if (c <= 3) span = 4 * exp_n(c);
      else span = 4 * exp_n(c) * exp_div(c);
      hold = 1 + int'($urandom % 32'(span));
      for (int i = 0; i < 3000; i++) begin
        clkin_tick = 1'($urandom % 2);
        dts_tick   = 1'($urandom % 2);
        nbr_in     = 1'($urandom % 2);
        trig_in    = 1'($urandom % 2);
        if (($urandom % 100) == 0) chan_en = ~chan_en;
        sel_wr    = (($urandom % 40) == 0);
        sel_wdata = 2'($urandom % 4);
        code_wr    = (i == 1000) || (i == 1100);
        code_wdata = (i == 1000) ? 4'($urandom % 16) : 4'(c);
        hold--;
        if (hold <= 0) begin
          pin_raw = ~pin_raw;
          hold = 1 + int'($urandom % 32'(span));
        end
        @(negedge clk);
      end
      sel_wr = 1'b0;
      code_wr = 1'b0;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule